// File: doc/BRIEF.md
# Starvation-Bounded Shared Memory Arbiter

This block picks, every clock cycle, one winner among the requesters of a shared on-chip memory. There are eight processor cores and two system-fabric ports. A core request is tagged either urgent or prefetch, and the block takes its priority from one of two per-core priority inputs according to that tag. A fabric request carries a single priority input per port. The lowest numeric priority wins, and ties rotate round-robin.

Each requester also has an 8-bit starvation bound. A per-requester wait counter counts the cycles that the requester spends pending without a grant. Once the counter reaches the bound, the requester is lifted above every ordinary priority until it is served. When the mode input selects the external-DRAM target, each bound is scaled by 16, so the longest wait grows from 255 to 4080 cycles. The memory array and the DRAM controller are outside the block. Only the selection, the promotion and the counting are modelled.

Top module: `sbarb_top`

## Requirements
- R1: `gnt` has at most one bit set. A set bit always matches a set `req` bit, and some bit is set whenever any `req` bit is set. The grant is combinational from the current inputs and state.
- R2: Index mapping is fixed. Bits 0..7 are cores 0..7 and bits 8..9 are fabric ports 0..1. A core's priority is its `urg_pri` field when its `urgent` bit is 1, and its `pf_pri` field otherwise. A fabric port's priority is its `fab_pri` field. Every priority field is 3 bits at slice `[i*3 +: 3]`. The lowest value wins.
- R3: Among tied requesters, the search starts at the index just after the last granted index and wraps around. After reset the search starts at index 0.
- R4: A requester's wait counter rises by one in each cycle in which it requests and is not granted. It clears on the edge after a grant. It holds its value while the requester has no request.
- R5: A requester whose wait counter is at or above its limit is promoted. A promoted requester outranks every requester that is not promoted, whatever their priorities.
- R6: A bound of 0 disables promotion for that requester. Its bound field is `bound[i*8 +: 8]`.
- R7: With `dram_tgt` = 1 the limit is bound×16. With `dram_tgt` = 0 the limit is the bound itself.
- R8: When several requesters are promoted at once, they are served in round-robin order as in R3.
- R9: After reset, all wait counters are zero and `gnt` is 0 while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dram_tgt | input | 1 | 1 selects the DRAM target, which scales the bounds by 16 |
| req | input | 10 | Request per requester |
| urgent | input | 8 | Per-core urgent tag |
| pf_pri | input | 24 | Per-core prefetch priority, 3 bits each |
| urg_pri | input | 24 | Per-core urgent priority, 3 bits each |
| fab_pri | input | 6 | Per-fabric-port priority, 3 bits each |
| bound | input | 80 | Per-requester starvation bound, 8 bits each |
| gnt | output | 10 | One-hot grant |

## Verification
A wait counter that does not clear or does not hold shows up at `gnt`. A low-priority requester then wins earlier or later than its bound predicts, and the error appears in the exact cycle of the promotion, not several cycles later. A wrong round-robin pointer shows up in the next tied cycle as a repeated or skipped index. A missing ×16 scaling moves the first promoted grant from cycle 16 to cycle 1.

// File: rtl/sbarb_pkg.sv
package sbarb_pkg;
    localparam int unsigned DEF_NCORE = 8;
    localparam int unsigned DEF_NFAB  = 2;
    localparam int unsigned DEF_PW    = 3;
    localparam int unsigned DEF_BW    = 8;
    localparam int unsigned DEF_SH    = 4;
endpackage

// File: rtl/sbarb_wait_ctr.sv
module sbarb_wait_ctr #(
    parameter int unsigned BW = 8,
    parameter int unsigned SH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          gnt,
    input  logic          dram_tgt,
    input  logic [BW-1:0] bound,
    output logic          promo
);
    localparam int unsigned CW = BW + SH;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_state_t;

    ctr_state_t    st_d, st_q;
    logic [CW-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = dram_tgt ? {bound, {SH{1'b0}}} : {{SH{1'b0}}, bound};
        promo = (bound != '0) && (st_q.cnt >= limit);
        if (gnt)
            st_d.cnt = '0;
        else if (req && (st_q.cnt != {CW{1'b1}}))
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R4
    clear_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |=> (st_q.cnt == '0));

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !gnt) |=> $stable(st_q.cnt));

    // R6
    zero_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bound == '0) |-> !promo);
endmodule

// File: rtl/sbarb_select.sv
module sbarb_select #(
    parameter int unsigned N  = 10,
    parameter int unsigned KW = 4,
    parameter int unsigned IW = 4
) (
    input  logic [N-1:0]    req,
    input  logic [N*KW-1:0] key_flat,
    input  logic [IW-1:0]   ptr,
    output logic [N-1:0]    gnt,
    output logic [IW-1:0]   gnt_idx
);
    logic [KW-1:0] best;
    logic          found;

    always_comb begin
        best = {KW{1'b1}};
        for (int i = 0; i < N; i++) begin
            if (req[i] && (key_flat[i*KW +: KW] < best))
                best = key_flat[i*KW +: KW];
        end
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = int'(ptr) + k;
            if (j >= N) j = j - N;
            if (!found && req[j] && (key_flat[j*KW +: KW] == best)) begin
                gnt[j]  = 1'b1;
                gnt_idx = IW'(j);
                found   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbarb_top.sv
module sbarb_top
    import sbarb_pkg::*;
#(
    parameter int unsigned NCORE = DEF_NCORE,
    parameter int unsigned NFAB  = DEF_NFAB,
    parameter int unsigned PW    = DEF_PW,
    parameter int unsigned BW    = DEF_BW,
    parameter int unsigned SH    = DEF_SH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dram_tgt,
    input  logic [NCORE+NFAB-1:0]      req,
    input  logic [NCORE-1:0]           urgent,
    input  logic [NCORE*PW-1:0]        pf_pri,
    input  logic [NCORE*PW-1:0]        urg_pri,
    input  logic [NFAB*PW-1:0]         fab_pri,
    input  logic [(NCORE+NFAB)*BW-1:0] bound,
    output logic [NCORE+NFAB-1:0]      gnt
);
    localparam int unsigned N  = NCORE + NFAB;
    localparam int unsigned KW = PW + 1;
    localparam int unsigned IW = $clog2(N);

    typedef struct packed {
        logic [IW-1:0] ptr;
    } rr_state_t;

    rr_state_t       st_d, st_q;
    logic [N-1:0]    promo;
    logic [N*KW-1:0] key_flat;
    logic [IW-1:0]   gnt_idx;

    for (genvar i = 0; i < N; i++) begin : g_req
        logic [PW-1:0] base;
        if (i < NCORE) begin : g_core
            assign base = urgent[i] ? urg_pri[i*PW +: PW] : pf_pri[i*PW +: PW];
        end else begin : g_fab
            assign base = fab_pri[(i-NCORE)*PW +: PW];
        end
        assign key_flat[i*KW +: KW] = promo[i] ? '0 : ({1'b0, base} + 1'b1);

        sbarb_wait_ctr #(.BW(BW), .SH(SH)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (req[i]),
            .gnt      (gnt[i]),
            .dram_tgt (dram_tgt),
            .bound    (bound[i*BW +: BW]),
            .promo    (promo[i])
        );
    end

    sbarb_select #(.N(N), .KW(KW), .IW(IW)) u_sel (
        .req      (req),
        .key_flat (key_flat),
        .ptr      (st_q.ptr),
        .gnt      (gnt),
        .gnt_idx  (gnt_idx)
    );

    always_comb begin
        st_d = st_q;
        if (|gnt)
            st_d.ptr = gnt_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q.ptr <= IW'(N - 1);
        else
            st_q <= st_d;
    end

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R1
    grant_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

    // R1
    no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|gnt));

    // R5
    promoted_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(promo & req)) |-> (|(gnt & promo)));
endmodule

// File: tb/sbarb_top_test.sv
module sbarb_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dram_tgt = 1'b0;
    logic [9:0]  req = '0;
    logic [7:0]  urgent = '0;
    logic [23:0] pf_pri;
    logic [23:0] urg_pri;
    logic [5:0]  fab_pri;
    logic [79:0] bound = '0;
    logic [9:0]  gnt;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbarb_top uut (
        .clk(clk), .rst_n(rst_n), .dram_tgt(dram_tgt), .req(req),
        .urgent(urgent), .pf_pri(pf_pri), .urg_pri(urg_pri),
        .fab_pri(fab_pri), .bound(bound), .gnt(gnt)
    );

    // {req[9:0], urgent[7:0], expected gnt[9:0]}
    localparam logic [27:0] VEC [11] = '{
        {10'h001, 8'h00, 10'h001},
        {10'h0FF, 8'h00, 10'h001},
        {10'h024, 8'h20, 10'h020},
        {10'h102, 8'h02, 10'h100},
        {10'h140, 8'h40, 10'h040},
        {10'h210, 8'h00, 10'h010},
        {10'h000, 8'h00, 10'h000},
        {10'h081, 8'h01, 10'h001},
        {10'h00C, 8'h0C, 10'h004},
        {10'h300, 8'h00, 10'h100},
        {10'h200, 8'hFF, 10'h200}
    };

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: gnt actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req = '0;
        urgent = '0;
        dram_tgt = 1'b0;
        bound = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_bound(input int i, input int v);
        bound[i*8 +: 8] = v[7:0];
    endtask

    // check at 1 time unit after the negedge, then move to the next negedge
    task automatic step(input string tag, input logic [9:0] exp);
        #1;
        check(tag, gnt, exp);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            pf_pri[i*3 +: 3]  = 3'd7;
            urg_pri[i*3 +: 3] = (i < 4) ? 3'd6 : 3'd3;
        end
        fab_pri = {3'd7, 3'd5};
        @(negedge clk);

        // R9: reset state, no requests
        do_reset();
        step("R9 idle after reset", 10'h000);

        // R2 / R3 table: each vector starts from reset, bounds 0
        for (int v = 0; v < 11; v++) begin
            do_reset();
            req    = VEC[v][27:18];
            urgent = VEC[v][17:10];
            #1;
            check($sformatf("R2 vector %0d", v), gnt, VEC[v][9:0]);
            n_chk++;
            if ($countones(gnt) > 1) begin
                n_bad++;
                $display("FAIL R1 vector %0d: gnt actual=%h expected=onehot", v, gnt);
            end
            @(negedge clk);
        end

        // R3: round-robin rotation among equal priorities
        do_reset();
        req = 10'h0FF;
        for (int k = 0; k < 9; k++)
            step($sformatf("R3 rotation step %0d", k), 10'(1) << (k % 8));

        // R5 / R4: core7 bound 3 promotes past urgent core0
        do_reset();
        req = 10'h081; urgent = 8'h01; set_bound(7, 3);
        for (int k = 0; k < 8; k++)
            step($sformatf("R5 promote step %0d", k), (k % 4 == 3) ? 10'h080 : 10'h001);

        // R7: DRAM target scales bound 1 to 16
        do_reset();
        dram_tgt = 1'b1;
        req = 10'h081; urgent = 8'h01; set_bound(7, 1);
        for (int k = 0; k < 17; k++)
            step($sformatf("R7 scaled step %0d", k), (k == 16) ? 10'h080 : 10'h001);

        // R6: bound 0 never promotes
        do_reset();
        req = 10'h081; urgent = 8'h01;
        begin
            int wins7;
            wins7 = 0;
            for (int k = 0; k < 300; k++) begin
                #1;
                if (gnt[7]) wins7++;
                @(negedge clk);
            end
            n_chk++;
            if (wins7 != 0) begin
                n_bad++;
                $display("FAIL R6 disabled bound: grants actual=%0d expected=0", wins7);
            end
        end

        // R4: counter holds while request is dropped
        do_reset();
        req = 10'h081; urgent = 8'h01; set_bound(7, 5);
        for (int k = 0; k < 3; k++) step("R4 before drop", 10'h001);
        req = 10'h001;
        for (int k = 0; k < 10; k++) step("R4 during drop", 10'h001);
        req = 10'h081;
        step("R4 resume wait 3", 10'h001);
        step("R4 resume wait 4", 10'h001);
        step("R4 resume promoted", 10'h080);

        // R8: two promoted requesters served in rotation
        do_reset();
        req = 10'h0C1; urgent = 8'h01; set_bound(6, 2); set_bound(7, 2);
        step("R8 step 0", 10'h001);
        step("R8 step 1", 10'h001);
        step("R8 first promoted", 10'h040);
        step("R8 second promoted", 10'h080);
        step("R8 back to core0", 10'h001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule